// File: doc/BRIEF.md
# Temperature Result Post-Processor

This block turns raw per-channel temperature readings into the words a host later reads back. Each reading is a 16-bit two's-complement value with 1/64 degree per LSB, so the 1-degree weight sits at bit 6. A reading arrives with its channel index. Words in the range 8000h to 81FFh are error codes. An error code is handed straight to the output and leaves all channel state alone.

A valid reading first goes through a per-channel exponential moving average whose weight is a power of two, set by an 8-bit shift count. The result is kept internally at full 1/64-degree resolution as that channel's history. The averaged value can then be converted to an integer-degree format. This conversion is an arithmetic right shift, so the high byte holds copies of the sign. A programmable offset, held in whichever format is current, is added next. The sum is clamped so that it never lands on an error code.

The offset is stored inside the block. When the format select changes, the stored offset is rescaled to the new format on its own. The processed word appears one clock after the reading, tagged with its channel.

Top module: `temp_postproc`

## Requirements
- R1: An input word with bits 15:9 equal to 1000000b (8000h to 81FFh) is output unchanged, and the history of its channel is not updated, so the next valid reading on that channel averages against the value held before the error.
- R2: The first valid reading on a channel after reset is taken as that channel's history directly, with no averaging.
- R3: For shift count n > 0 and a channel that already has history H, a valid reading S gives A = H + ((S − H) >>> n), computed in signed 17-bit arithmetic. A becomes the new history.
- R4: With n = 0, A equals the reading itself.
- R5: Each channel keeps its own history and its own first-reading state. Readings on one channel never change the result of another channel.
- R6: With the format select at 1 (integer format), the converted value is A >>> 6, an arithmetic shift. With the format select at 0, it is A unchanged.
- R7: The stored offset, read as a signed 16-bit value, is added to the converted value of every valid reading. An error code gets no offset.
- R8: For a valid reading, the sum is clamped to the range 8200h (−32256) to 7FFFh (+32767), so the output is never an error code.
- R9: On a change of the format select, the stored offset is rescaled. Going 0→1 it becomes offset >>> 6. Going 1→0 it becomes offset × 64, saturated to the signed 16-bit range. An offset write in the same cycle takes priority over the rescaling and is stored as written.
- R10: After reset, out_valid is 0, out_data and offset are 0000h, the format is 0, and every channel is without history.
- R11: The result appears exactly one clock after in_valid, with out_ch equal to the input channel. The format and offset used are the values registered before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A reading is present this cycle |
| in_ch | input | $clog2(NUM_CH) | Channel of the reading |
| in_data | input | 16 | Raw reading or error code |
| avg_shift | input | 8 | Averaging shift count n |
| alt_fmt | input | 1 | 1 selects the integer-degree format |
| ofs_we | input | 1 | Write strobe for the offset |
| ofs_wdata | input | 16 | Offset value, in the format now selected |
| out_valid | output | 1 | Result present |
| out_ch | output | $clog2(NUM_CH) | Channel of the result |
| out_data | output | 16 | Processed word |
| ofs_q | output | 16 | Stored offset in the current format |

## Verification
The bench builds the block with its defaults: eight channels, with a fraction width of 6 bits. Eight channels let the run seed, average and interleave several channels in the same pass. The 6-bit fraction makes the 17C0h / 005Fh offset pair reachable across a format change. Shift counts from 0 to 4 together with the clamp bounds cover both rounding signs of the average, as well as both saturation edges. The run also includes readings just outside the error window, 8200h and 7FFFh.

// File: rtl/temp_postproc.sv
module temp_postproc #(
  parameter int NUM_CH = 8,
  parameter int FRAC   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [$clog2(NUM_CH)-1:0] in_ch,
  input  logic [15:0]               in_data,
  input  logic [7:0]                avg_shift,
  input  logic                      alt_fmt,
  input  logic                      ofs_we,
  input  logic [15:0]               ofs_wdata,
  output logic                      out_valid,
  output logic [$clog2(NUM_CH)-1:0] out_ch,
  output logic [15:0]               out_data,
  output logic [15:0]               ofs_q
);
  localparam int CHW = $clog2(NUM_CH);
  localparam logic signed [17:0] SUM_MAX = 18'sd32767;
  localparam logic signed [17:0] SUM_MIN = -18'sd32256;
  localparam logic signed [15+FRAC:0] UP_MAX = (16+FRAC)'(32767);
  localparam logic signed [15+FRAC:0] UP_MIN = -(16+FRAC)'(32768);

  logic [15:0]       hist [NUM_CH];
  logic [NUM_CH-1:0] seen;
  logic              fmt_q;

  logic                     is_err;
  logic [15:0]              old;
  logic signed [16:0]       diff, step;
  logic signed [15:0]       avg, conv;
  logic signed [17:0]       sum;
  logic [15:0]              res;
  logic signed [15+FRAC:0]  up;
  logic [15:0]              ofs_up, ofs_dn;

  assign is_err = (in_data[15:9] == 7'b1000000);
  assign old    = hist[in_ch];
  assign diff   = $signed({in_data[15], in_data}) - $signed({old[15], old});
  assign step   = diff >>> avg_shift;
  assign avg    = (seen[in_ch] && avg_shift != 8'd0) ? $signed(16'(17'(step) + {old[15], old}))
                                                     : $signed(in_data);
  assign conv   = fmt_q ? (avg >>> FRAC) : avg;
  assign sum    = 18'(conv) + 18'($signed(ofs_q));

  always_comb begin
    if (is_err)              res = in_data;
    else if (sum > SUM_MAX)  res = 16'h7FFF;
    else if (sum < SUM_MIN)  res = 16'h8200;
    else                     res = sum[15:0];
  end

  assign up     = (16+FRAC)'($signed(ofs_q)) <<< FRAC;
  assign ofs_up = (up > UP_MAX) ? 16'h7FFF : (up < UP_MIN) ? 16'h8000 : up[15:0];
  assign ofs_dn = 16'($signed(ofs_q) >>> FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
      ofs_q     <= '0;
      fmt_q     <= 1'b0;
      seen      <= '0;
      for (int i = 0; i < NUM_CH; i++) hist[i] <= '0;
    end else begin
      out_valid <= in_valid;
      fmt_q     <= alt_fmt;
      if (ofs_we)                ofs_q <= ofs_wdata;
      else if (alt_fmt && !fmt_q) ofs_q <= ofs_dn;
      else if (!alt_fmt && fmt_q) ofs_q <= ofs_up;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_data <= res;
        if (!is_err) begin
          hist[in_ch] <= avg;
          seen[in_ch] <= 1'b1;
        end
      end
    end
  end

  p_err_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_err |=> out_valid && out_data == $past(in_data));

  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_err && !seen[in_ch] && !fmt_q && ofs_q == 16'h0 |=> out_data == $past(in_data));

  p_no_err_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_err |=> out_data[15:9] != 7'b1000000);

  p_rescale_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_we && !fmt_q && alt_fmt |=> ofs_q == 16'($signed($past(ofs_q)) >>> FRAC));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_ch == $past(in_ch));

  p_hist_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_err |=> $stable(seen));

  logic [CHW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/temp_postproc_bench.sv
module temp_postproc_bench;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [2:0] in_ch = 0;
  logic [15:0] in_data = 0;
  logic [7:0] avg_shift = 0;
  logic alt_fmt = 0, ofs_we = 0;
  logic [15:0] ofs_wdata = 0;
  logic out_valid;
  logic [2:0] out_ch;
  logic [15:0] out_data, ofs_q;

  int total = 0, bad = 0;
  int q_ch[$], q_data[$], q_req[$];
  int m_hist[NCH];
  bit m_seen[NCH];
  int m_ofs = 0;
  bit m_fmt = 0;

  always #5 clk = ~clk;

  temp_postproc u_temp_postproc (.clk, .rst_n, .in_valid, .in_ch, .in_data, .avg_shift,
    .alt_fmt, .ofs_we, .ofs_wdata, .out_valid, .out_ch, .out_data, .ofs_q);

  task automatic check(input int req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic sample(input int ch, input logic [15:0] d, input int req);
    int a, v, sm;
    if (d[15:9] == 7'b1000000) v = int'(d);
    else begin
      if (!m_seen[ch] || avg_shift == 0) a = s16(d);
      else a = m_hist[ch] + ((s16(d) - m_hist[ch]) >>> avg_shift);
      m_hist[ch] = a; m_seen[ch] = 1;
      sm = (m_fmt ? (a >>> 6) : a) + m_ofs;
      if (sm > 32767) sm = 32767;
      if (sm < -32256) sm = -32256;
      v = sm & 16'hFFFF;
    end
    q_ch.push_back(ch); q_data.push_back(v); q_req.push_back(req);
    @(negedge clk);
    in_valid = 1; in_ch = 3'(ch); in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic set_ofs(input logic [15:0] w);
    @(negedge clk); ofs_we = 1; ofs_wdata = w;
    @(negedge clk); ofs_we = 0;
    m_ofs = s16(w);
  endtask

  task automatic set_fmt(input bit f);
    int up;
    @(negedge clk); alt_fmt = f;
    @(negedge clk);
    if (f && !m_fmt) m_ofs = m_ofs >>> 6;
    else if (!f && m_fmt) begin
      up = m_ofs * 64;
      m_ofs = (up > 32767) ? 32767 : (up < -32768) ? -32768 : up;
    end
    m_fmt = f;
    check(9, int'(ofs_q), m_ofs & 16'hFFFF);  // R9
  endtask

  // monitor: pops expected items as results emerge
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) check(11, 1, 0);
      else begin
        int rq = q_req.pop_front();
        check(11, int'(out_ch), q_ch.pop_front());  // R11
        check(rq, int'(out_data), q_data.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL R11 actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10, int'(out_valid), 0);   // R10
    check(10, int'(ofs_q), 0);       // R10
    check(10, int'(out_data), 0);    // R10
    rst_n = 1;
    @(negedge clk);
    // R4, R2: pass-through with n = 0
    avg_shift = 0;
    sample(0, 16'h0640, 2);
    sample(0, 16'hF380, 4);
    // R3: averaging with n = 2
    avg_shift = 2;
    sample(1, 16'h1000, 2);
    sample(1, 16'h2000, 3);   // 1400h
    sample(1, 16'h0000, 3);   // 0F00h
    // R1: error codes bypass and leave history alone
    sample(1, 16'h8100, 1);
    sample(1, 16'h81FF, 1);
    sample(1, 16'h8000, 1);
    sample(1, 16'h0F00, 1);   // still 0F00h
    sample(2, 16'h8200, 2);   // just outside error window, seeds
    // R5: independent channels interleaved
    sample(3, 16'h0100, 5);
    sample(1, 16'h1F00, 5);
    sample(3, 16'h0500, 5);
    // R7: offset in 16-bit format
    avg_shift = 0;
    set_ofs(16'h17C0);
    sample(4, 16'hFFC0, 7);   // 1780h
    // R9 to integer format, R6 conversion
    set_fmt(1);               // offset 005Fh
    sample(4, 16'hFFC0, 6);   // 005Eh
    sample(5, 16'hF380, 7);   // 002Dh
    set_ofs(16'h0000);
    sample(6, 16'hF380, 6);   // FFCEh
    set_ofs(16'h005F);
    set_fmt(0);               // R9 back to 17C0h
    set_fmt(1);
    set_ofs(16'h7000);
    set_fmt(0);               // R9 saturates to 7FFFh
    // R9: write wins over rescale
    @(negedge clk); alt_fmt = 1; ofs_we = 1; ofs_wdata = 16'h1234;
    @(negedge clk); ofs_we = 0; alt_fmt = 0;
    check(9, int'(ofs_q), 16'h1234);   // R9
    @(negedge clk);
    m_ofs = 16'h1234; m_fmt = 0;
    check(9, int'(ofs_q), 16'h7FFF & 16'hFFFF); // 1→0 rescale of 1234h saturates
    m_ofs = 32767;
    // R8: clamps
    sample(7, 16'h1000, 8);   // 7FFFh
    set_ofs(16'h8000);
    sample(7, 16'h0000, 8);   // 8200h
    sample(7, 16'h8101, 8);   // error still raw
    set_ofs(16'h0000);
    // mixed run
    for (int i = 0; i < 300; i++) begin
      logic [15:0] d;
      avg_shift = 8'($urandom_range(0, 4));
      d = 16'($urandom);
      if (i % 7 == 0) d = {7'b1000000, 9'($urandom)};
      sample($urandom_range(0, NCH - 1), d, 3);
    end
    repeat (4) @(negedge clk);
    check(11, q_data.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule